// File: doc/BRIEF.md
# Asynchronous DRAM Access Controller

This block connects a simple request/acknowledge host port to an asynchronous 256K x 8 DRAM whose row and column addresses share one set of pins. The host presents an 18-bit byte address, a write flag and a write byte, and holds its request until it sees an acknowledge. The controller splits the address into two 9-bit halves and sends them across two falling strobe edges. It drives the four active-low strobes and turns the single bidirectional data pin around between write and read cycles.

Refresh is built in. A free-running timer asks for one refresh every `REFRESH_INTERVAL` clocks. Each refresh is a cycle in which only the row strobe falls. It targets the next row of a wrapping row counter. A refresh waits for any access already under way to finish, and it wins over a host request that is pending at the same time. The length of each phase is a clock-count parameter, so the same logic can be tuned to a given clock rate and speed grade.

Top module: `dram_access_ctrl`

## Requirements
- R1: While reset is asserted, and until the first request after it, `ras_n`, `cas_n`, `we_n` and `oe_n` are high and `host_ack` is low.
- R2: A host access uses `host_addr[17:9]` as the row and `host_addr[8:0]` as the column. The column is on `mem_addr` for at least one clock before `cas_n` falls, and `ras_n` is low at that edge.
- R3: The row is on `mem_addr` for at least one clock before `ras_n` falls. `ras_n` then stays low for `T_RCD` clocks before the column is put on the pins.
- R4: A write uses the early-write form. `we_n` is low, `oe_n` is high and the write byte is on `mem_dq` for at least one clock before `cas_n` falls. The byte at the addressed location is replaced.
- R5: A read uses the early-read form. `oe_n` is low and `we_n` is high for at least one clock before `cas_n` falls. The controller does not drive `mem_dq` while `oe_n` is low, nor in the clock before. The byte on `mem_dq` is captured on the last clock of the column-strobe phase.
- R6: `host_ack` is high for exactly one clock, in the first clock after `cas_n` rises. For a read, `host_rdata` holds the captured byte in that clock.
- R7: Between two cycles, `ras_n` stays high for at least `T_RP + 2` clocks. This covers the precharge, at least one idle clock and the row setup clock.
- R8: `host_req`, `host_write`, `host_addr` and `host_wdata` are sampled only while the controller is idle. Changing them during an access has no effect on that access.
- R9: A refresh is a cycle in which only the row strobe falls. `cas_n`, `we_n` and `oe_n` stay high throughout. The refreshed rows run 0, 1, 2, … and wrap from 511 to 0.
- R10: A refresh request is raised every `REFRESH_INTERVAL` clocks. With no host traffic, successive refresh row-strobe falls are exactly `REFRESH_INTERVAL` clocks apart.
- R11: When a refresh and a host request are both pending in the idle state, the refresh starts first. A refresh never interrupts an access in progress, so a host that keeps its request asserted cannot starve refresh.
- R12: During a host access, `cas_n` is low for exactly `T_CAS` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host request, held until acknowledged |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Byte address; upper half is the row, lower half the column |
| host_wdata | input | 8 | Write byte |
| host_ack | output | 1 | One-clock completion pulse |
| host_rdata | output | 8 | Captured read byte, valid with `host_ack` |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 9 | Shared row/column address pins |
| mem_dq | inout | 8 | Bidirectional data pin |

## Verification
The bench attaches a behavioural DRAM to the pins. The model latches the row and column on strobe edges, stores written bytes and returns them on reads. This way, an address that is swapped, mis-split or changes in the same clock as its strobe shows up as wrong data or a wrong latched address.

It scrambles the host fields in the middle of back-to-back accesses while the request stays asserted. A controller that samples its inputs outside idle would then write or read the wrong location, or swap the operation.

A long idle run walks the refresh counter through its wrap. It checks the exact spacing of refresh cycles and that CAS stays quiet during them. The same held-request stream shows whether refresh is starved when host requests are given priority.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  // Sequencer phases; every cycle starts in ST_ROW.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ROW    = 3'd1,
    ST_COL    = 3'd2,
    ST_ACCESS = 3'd3,
    ST_PRE    = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_REFRESH = 2'd2
  } op_kind_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 780,
  parameter int ROW_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);

  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;
  logic             pend_q, pend_d;
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    wrap   = (cnt_q == CNT_LAST);
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    pend_d = pend_q;
    if (grant_i) pend_d = 1'b0;
    if (wrap)    pend_d = 1'b1;
    row_d  = row_q + 1'b1;   // wraps naturally at 2**ROW_W rows
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (grant_i) begin
      row_q <= row_d;
    end
  end

  assign pend_o = pend_q;
  assign row_o  = row_q;

  // R10: a request appears only as the interval counter wraps
  a_r10_pend_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(cnt_q) == CNT_LAST));

  // R9: each granted refresh advances the row by one
  a_r9_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |=> (row_q == $past(row_q) + 1'b1));

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DATA_W = 8,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 3,
  parameter int T_RP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_write,
  input  logic [ROW_W-1:0]  host_row,
  input  logic [COL_W-1:0]  host_col,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              rfsh_pend,
  input  logic [ROW_W-1:0]  rfsh_row,
  output logic              rfsh_grant,
  output seq_state_e        state_o,
  output op_kind_e          op_o,
  output logic              row_setup_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] dq_sample,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int MAXPH = max3(T_RCD + 1, T_CAS, T_RP);
  localparam int CNT_W = $clog2(MAXPH + 1);

  seq_state_e        state_q, state_d;
  op_kind_e          op_q, op_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              ack_q, ack_d;
  logic              phase_last;
  logic              load_rfsh, load_host, cap_rd;

  // Last clock of the current phase
  always_comb begin
    case (state_q)
      ST_ROW:    phase_last = (cnt_q == CNT_W'(T_RCD));
      ST_COL:    phase_last = 1'b1;
      ST_ACCESS: phase_last = (cnt_q == CNT_W'(T_CAS - 1));
      ST_PRE:    phase_last = (cnt_q == CNT_W'(T_RP - 1));
      default:   phase_last = 1'b0;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    load_rfsh = 1'b0;
    load_host = 1'b0;
    cap_rd    = 1'b0;
    ack_d     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (rfsh_pend) begin
          load_rfsh = 1'b1;
          state_d   = ST_ROW;
        end else if (host_req) begin
          load_host = 1'b1;
          state_d   = ST_ROW;
        end
      end
      ST_ROW: begin
        if (phase_last) state_d = (op_q == OP_REFRESH) ? ST_ACCESS : ST_COL;
      end
      ST_COL: state_d = ST_ACCESS;
      ST_ACCESS: begin
        if (phase_last) begin
          state_d = ST_PRE;
          ack_d   = (op_q != OP_REFRESH);
          cap_rd  = (op_q == OP_READ);
        end
      end
      ST_PRE: begin
        if (phase_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    if (state_d != state_q)      cnt_d = '0;
    else if (state_q != ST_IDLE) cnt_d = cnt_q + 1'b1;
    else                         cnt_d = cnt_q;

    if (load_rfsh)       op_d = OP_REFRESH;
    else if (host_write) op_d = OP_WRITE;
    else                 op_d = OP_READ;
  end

  // Sequencer registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ack_q   <= ack_d;
    end
  end

  // Command capture: only while idle and starting a cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_READ;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else begin
      if (load_rfsh || load_host) begin
        op_q  <= op_d;
        row_q <= load_rfsh ? rfsh_row : host_row;
      end
      if (load_host) begin
        col_q   <= host_col;
        wdata_q <= host_wdata;
      end
    end
  end

  // Read capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= dq_sample;
  end

  assign rfsh_grant  = load_rfsh;
  assign state_o     = state_q;
  assign op_o        = op_q;
  assign row_setup_o = (state_q == ST_ROW) && (cnt_q == '0);
  assign row_o       = row_q;
  assign col_o       = col_q;
  assign wdata_o     = wdata_q;
  assign ack_o       = ack_q;
  assign rdata_o     = rdata_q;

  // R11: pending refresh wins in idle
  a_r11_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && rfsh_pend) |=> (state_q == ST_ROW && op_q == OP_REFRESH));

  // R8: captured command frozen once a cycle is under way
  a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(row_q) && $stable(op_q) && $stable(col_q)));

  // R6: acknowledge is a single pulse in the first precharge clock
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  a_r6_ack_in_pre: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (state_q == ST_PRE && cnt_q == '0));

endmodule

// File: rtl/dram_pin_io.sv
module dram_pin_io
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_i,
  input  op_kind_e          op_i,
  input  logic              row_setup_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] dq_sample,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ROW_W-1:0]  mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);

  logic in_col_or_acc;
  logic drv;
  logic col_on_pins;

  always_comb begin
    in_col_or_acc = (state_i == ST_COL) || (state_i == ST_ACCESS);
    ras_n = !(((state_i == ST_ROW) && !row_setup_i) || in_col_or_acc);
    cas_n = !((state_i == ST_ACCESS) && (op_i != OP_REFRESH));
    we_n  = !(in_col_or_acc && (op_i == OP_WRITE));
    oe_n  = !(in_col_or_acc && (op_i == OP_READ));
    drv   = in_col_or_acc && (op_i == OP_WRITE);
    col_on_pins = (state_i == ST_COL) ||
                  ((state_i == ST_ACCESS) && (op_i != OP_REFRESH));
    mem_addr = col_on_pins ? ROW_W'(col_i) : row_i;
  end

  assign mem_dq    = drv ? wdata_i : {DATA_W{1'bz}};
  assign dq_sample = mem_dq;

  // R5: pin released a clock before and while output enable is low
  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!drv && !$past(drv)));

  // R3: row stable across the row strobe edge
  a_r3_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(mem_addr));

  // R2: column stable across the column strobe edge, row strobe low
  a_r2_col_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ($stable(mem_addr) && !ras_n));

  // R4 / R5: early forms, direction set before the column strobe
  a_r4_early_dir: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ($stable(we_n) && $stable(oe_n) && (we_n != oe_n)));

  // R9: refresh keeps column strobe and direction strobes high
  a_r9_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_REFRESH && !ras_n) |-> (cas_n && we_n && oe_n));

  // R7: row strobe held high after rising
  a_r7_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);

endmodule

// File: rtl/dram_access_ctrl.sv
module dram_access_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ADDR_W           = 18,
  parameter int DATA_W           = 8,
  parameter int T_RCD            = 2,
  parameter int T_CAS            = 3,
  parameter int T_RP             = 2,
  parameter int REFRESH_INTERVAL = 780
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_req,
  input  logic                       host_write,
  input  logic [ADDR_W-1:0]          host_addr,
  input  logic [DATA_W-1:0]          host_wdata,
  output logic                       host_ack,
  output logic [DATA_W-1:0]          host_rdata,
  output logic                       ras_n,
  output logic                       cas_n,
  output logic                       we_n,
  output logic                       oe_n,
  output logic [(ADDR_W+1)/2-1:0]    mem_addr,
  inout  wire  [DATA_W-1:0]          mem_dq
);

  localparam int ROW_W = (ADDR_W + 1) / 2;
  localparam int COL_W = ADDR_W - ROW_W;

  // Asynchronous assert, synchronous release
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic              rfsh_pend, rfsh_grant;
  logic [ROW_W-1:0]  rfsh_row;
  seq_state_e        state;
  op_kind_e          op;
  logic              row_setup;
  logic [ROW_W-1:0]  row_cur;
  logic [COL_W-1:0]  col_cur;
  logic [DATA_W-1:0] wdata_cur;
  logic [DATA_W-1:0] dq_sample;

  dram_refresh_timer #(
    .INTERVAL (REFRESH_INTERVAL),
    .ROW_W    (ROW_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .grant_i (rfsh_grant),
    .pend_o  (rfsh_pend),
    .row_o   (rfsh_row)
  );

  dram_seq_fsm #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .T_RCD  (T_RCD),
    .T_CAS  (T_CAS),
    .T_RP   (T_RP)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .host_req    (host_req),
    .host_write  (host_write),
    .host_row    (host_addr[ADDR_W-1:COL_W]),
    .host_col    (host_addr[COL_W-1:0]),
    .host_wdata  (host_wdata),
    .rfsh_pend   (rfsh_pend),
    .rfsh_row    (rfsh_row),
    .rfsh_grant  (rfsh_grant),
    .state_o     (state),
    .op_o        (op),
    .row_setup_o (row_setup),
    .row_o       (row_cur),
    .col_o       (col_cur),
    .wdata_o     (wdata_cur),
    .dq_sample   (dq_sample),
    .ack_o       (host_ack),
    .rdata_o     (host_rdata)
  );

  dram_pin_io #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .state_i     (state),
    .op_i        (op),
    .row_setup_i (row_setup),
    .row_i       (row_cur),
    .col_i       (col_cur),
    .wdata_i     (wdata_cur),
    .dq_sample   (dq_sample),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .oe_n        (oe_n),
    .mem_addr    (mem_addr),
    .mem_dq      (mem_dq)
  );

  // R1: strobes idle high whenever the controller is idle
  a_r1_idle_strobes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_IDLE) |-> (ras_n && cas_n && we_n && oe_n && !host_ack));

endmodule

// File: tb/dram_access_ctrl_test.sv
module dram_access_ctrl_test;

  localparam int T_RCD = 2;
  localparam int T_CAS = 3;
  localparam int T_RP  = 2;
  localparam int RINT  = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, wr;
  logic [17:0] addr;
  logic [7:0]  wdata;
  logic        ack;
  logic [7:0]  rdata;
  logic        ras_n, cas_n, we_n, oe_n;
  logic [8:0]  mem_addr;
  wire  [7:0]  mem_dq;

  logic        mdl_drv = 1'b0;
  logic [7:0]  mdl_q = 8'h00;
  assign mem_dq = mdl_drv ? mdl_q : 8'hzz;

  always #2 clk = ~clk;

  dram_access_ctrl #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .REFRESH_INTERVAL(RINT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .host_req(req), .host_write(wr),
    .host_addr(addr), .host_wdata(wdata), .host_ack(ack), .host_rdata(rdata),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .mem_addr(mem_addr), .mem_dq(mem_dq)
  );

  int n_chk = 0;
  int n_err = 0;
  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 37) ^ (a >> 9));
  endfunction

  // Behavioural DRAM attached to the pins
  logic [7:0] dmem [int];
  logic [7:0] shadow [int];

  logic       p_ras = 1, p_cas = 1, p_we = 1, p_oe = 1;
  logic [8:0] p_addr = 0;
  int  ras_hi = 0, cas_lo = 0;
  bit  seen_ras = 0;
  int  cyc_row = 0;
  bit  cyc_cas = 0, cyc_we = 0, cyc_oe = 0;
  int  cyc_fall_t = 0;
  int  last_row = -1, last_col = -1;
  bit  last_w = 0;
  int  exp_rrow = 0;
  int  rfsh_cnt = 0;
  bit  wrap_seen = 0;
  bit  spacing_on = 0;
  int  spacing_skip = 0;
  int  last_rfsh_t = 0;

  always @(negedge clk) begin
    if (mdl_drv && (cas_n || oe_n)) mdl_drv <= 1'b0;
    if (p_ras && !ras_n) begin
      check(p_addr == mem_addr, "R3 row setup", p_addr, mem_addr);
      if (seen_ras) check(ras_hi >= T_RP + 2, "R7 precharge", ras_hi, T_RP + 2);
      seen_ras = 1;
      cyc_row = mem_addr; cyc_cas = 0; cyc_we = 0; cyc_oe = 0;
      cyc_fall_t = cyc;
    end
    if (ras_n) ras_hi++; else ras_hi = 0;
    if (!ras_n) begin
      if (!we_n) cyc_we = 1;
      if (!oe_n) cyc_oe = 1;
    end
    if (p_cas && !cas_n) begin
      check(!ras_n, "R2 ras low at cas", ras_n, 0);
      check(p_addr == mem_addr, "R2 col setup", p_addr, mem_addr);
      cyc_cas = 1; cas_lo = 0;
      last_row = cyc_row; last_col = mem_addr;
      if (!we_n) begin
        check(!p_we && oe_n && p_oe, "R4 early write", p_we, 0);
        dmem[{cyc_row[8:0], mem_addr}] = mem_dq;
        last_w = 1;
      end else begin
        check(!p_oe && !oe_n, "R5 early read", p_oe, 0);
        mdl_q   <= dmem.exists(int'({cyc_row[8:0], mem_addr})) ?
                   dmem[int'({cyc_row[8:0], mem_addr})] :
                   pattern(int'({cyc_row[8:0], mem_addr}));
        mdl_drv <= 1'b1;
        last_w = 0;
      end
    end
    if (!cas_n) cas_lo++;
    if (!p_cas && cas_n) check(cas_lo == T_CAS, "R12 cas width", cas_lo, T_CAS);
    if (!p_ras && ras_n && !cyc_cas) begin
      check(!cyc_we && !cyc_oe, "R9 refresh quiet", cyc_we + cyc_oe, 0);
      check(cyc_row == exp_rrow, "R9 refresh row", cyc_row, exp_rrow);
      if (exp_rrow == 511) wrap_seen = 1;
      exp_rrow = (exp_rrow + 1) % 512;
      if (spacing_on) begin
        if (spacing_skip > 0) spacing_skip--;
        else check(cyc_fall_t - last_rfsh_t == RINT, "R10 spacing",
                   cyc_fall_t - last_rfsh_t, RINT);
      end
      last_rfsh_t = cyc_fall_t;
      rfsh_cnt++;
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_oe = oe_n; p_addr = mem_addr;
  end

  function automatic logic [7:0] expect_rd(input logic [17:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : pattern(int'(a));
  endfunction

  task automatic wait_ack(output bit got);
    int n = 0;
    got = 0;
    while (!got && n < 300) begin
      @(negedge clk);
      n++;
      got = ack;
    end
  endtask

  task automatic finish_ack(input logic w, input logic [17:0] a, input logic [7:0] d,
                            input bit got);
    check(got, "R6 ack seen", got, 1);
    check(last_row == int'(a[17:9]), "R2 row", last_row, a[17:9]);
    check(last_col == int'(a[8:0]), "R2 col", last_col, a[8:0]);
    check(last_w == w, "R8 op kind", last_w, w);
    if (!w) check(rdata == expect_rd(a), "R5 R6 read data", rdata, expect_rd(a));
    else shadow[int'(a)] = d;
  endtask

  task automatic host_op(input logic w, input logic [17:0] a, input logic [7:0] d);
    bit got;
    @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d;
    wait_ack(got);
    finish_ack(w, a, d, got);
    req = 0;
    @(negedge clk);
    check(!ack, "R6 ack one clock", ack, 0);
    check(ras_n, "R7 ras high after access", ras_n, 1);
  endtask

  // Held request with fields scrambled mid-access
  task automatic held_stream(input int n);
    bit got;
    int t0, r0;
    t0 = cyc; r0 = rfsh_cnt;
    @(negedge clk);
    req = 1;
    for (int k = 0; k < n; k++) begin
      logic [17:0] a;
      logic        w;
      logic [7:0]  d;
      a = {1'b1, 8'($urandom), 9'($urandom)};
      w = 1'($urandom);
      d = 8'($urandom);
      addr = a; wr = w; wdata = d;
      do @(negedge clk); while (!(!ras_n && mem_addr == a[17:9]));
      addr = ~a; wr = ~w; wdata = ~d;
      wait_ack(got);
      finish_ack(w, a, d, got);
    end
    req = 0;
    check(rfsh_cnt - r0 >= (int'(cyc) - t0) / RINT - 1, "R11 refresh not starved",
          rfsh_cnt - r0, (int'(cyc) - t0) / RINT - 1);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    rst_n = 0; req = 0; wr = 0; addr = 0; wdata = 0;
    repeat (4) @(negedge clk);
    check(ras_n && cas_n && we_n && oe_n, "R1 strobes in reset",
          {ras_n, cas_n, we_n, oe_n}, 15);
    check(!ack, "R1 ack in reset", ack, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(ras_n && cas_n && we_n && oe_n && !ack, "R1 idle after reset",
          {ras_n, cas_n, we_n, oe_n}, 15);

    // Directed corners
    host_op(0, 18'h00000, 8'h00);
    host_op(1, 18'h00000, 8'hA5);
    host_op(0, 18'h00000, 8'h00);
    host_op(1, 18'h3FFFF, 8'hFF);
    host_op(1, 18'h3FE00, 8'h00);
    host_op(0, 18'h3FFFF, 8'h00);
    host_op(0, 18'h3FE00, 8'h00);
    host_op(0, 18'h001FF, 8'h00);
    host_op(1, 18'h20001, 8'h5A);
    host_op(0, 18'h00201, 8'h00);
    host_op(0, 18'h20001, 8'h00);

    // Random mixed traffic, reads biased towards written locations
    for (int i = 0; i < 60; i++) begin
      logic [17:0] a;
      a = ($urandom % 2) ? {8'($urandom % 4), 10'($urandom % 8)} : 18'($urandom);
      host_op(1'($urandom), a, 8'($urandom));
    end

    held_stream(60);

    // Long idle: refresh spacing and row counter wrap
    repeat (2) @(negedge clk);
    spacing_skip = 2;
    spacing_on = 1;
    repeat (512 * RINT + 4 * RINT) @(negedge clk);
    spacing_on = 0;
    check(wrap_seen, "R9 row counter wrap", wrap_seen, 1);

    // Traffic again after wrap
    host_op(1, 18'h12345, 8'h3C);
    host_op(0, 18'h12345, 8'h00);

    summary();
    $finish;
  end

endmodule